// File: doc/BRIEF.md
# Resolution-Selectable Conversion Sequencer

This block paces the conversions of a temperature sensor front end. A small configuration register holds a 2-bit resolution code, a shutdown bit and a one-shot trigger bit. A prescaled timebase tick advances a conversion timer. Each code selects a conversion length, and the length doubles with each step of resolution. When a conversion finishes, the block samples the 12-bit converter result and zeroes the bits below the selected resolution. It then raises a one-clock sample-valid strobe. A busy flag is high for as long as a conversion is in progress.

With shutdown clear, the block converts continuously, and each conversion starts on the clock after the previous one completes. Setting shutdown lets the conversion in progress finish, and the block then stops. While the block is idle and shut down, a register write that sets both the one-shot bit and the shutdown bit runs exactly one conversion. After that conversion the block returns to idle on its own. The one-shot bit is a trigger only and never holds a value.

The sequencer has three states. `ST_IDLE` is not busy. It moves to `ST_CONT` when shutdown is clear, or to `ST_SINGLE` on an accepted one-shot trigger. `ST_CONT` is busy. At each completion it either restarts, or moves to `ST_IDLE` if shutdown is set. `ST_SINGLE` is busy and moves to `ST_IDLE` at its completion. The resolution code is captured when each conversion starts.

Top module: `conv_sequencer`

## Requirements
- R1: A synchronous reset clears busy and sample_valid and sets the register to continuous mode at code 00 (cfg_rdata reads 0). With shutdown clear, busy rises within two clocks after reset is released.
- R2: A conversion lasts UNIT_TICKS × 2^code timebase ticks. With the default of 2, codes 00, 01, 10 and 11 give 2, 4, 8 and 16 ticks.
- R3: In continuous mode, busy stays high and a new conversion starts on the clock after each completion. With a tick every D clocks, sample_valid therefore repeats every UNIT_TICKS × 2^code × D clocks.
- R4: sample_valid is high for exactly one clock per completed conversion, and only after a clock in which busy was high.
- R5: The latched sample is the converter input with its lowest 3 − code bits forced to zero. Code 00 keeps bits 11:3, 01 keeps 11:2, 10 keeps 11:1 and 11 keeps all 12 bits.
- R6: Writing shutdown = 1 (cfg_wdata bit 2) during continuous conversion lets the current conversion finish with a sample. busy falls on the same clock that sample_valid rises, and no further samples follow.
- R7: While the block is idle and shut down, a write with cfg_wdata bits 3 and 2 both set runs exactly one conversion. busy then returns low with the sample, and no further conversion starts.
- R8: cfg_rdata bit 3, the one-shot position, always reads 0. Bits 1:0 read the resolution code and bit 2 reads the shutdown bit.
- R9: A one-shot write during a conversion is ignored. Continuous mode keeps its period. A write that sets shutdown and one-shot together while a conversion is running only stops the block after the current conversion, and no extra conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled timebase tick, one clock wide |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {one-shot, shutdown, code[1:0]} |
| cfg_rdata | output | 4 | {0, shutdown, code[1:0]} |
| adc_raw | input | 12 | Raw converter result |
| busy | output | 1 | Conversion in progress |
| sample_valid | output | 1 | One-clock strobe when a new sample is latched |
| sample | output | 12 | Truncated sample |

## Verification
The checker watches several behaviours on every clock: the idle state right after reset, the strobe only ever following a busy clock, busy falling only together with a sample, the zeroed low bits of every sample, and the timer count staying inside the length for the captured code. Some behaviours appear only across a whole scenario, so only the bench's directed tests can show them. These are the exact spacing of samples for each code and tick rate, the single conversion after a one-shot trigger, silence for many clocks after shutdown, and the dropping of one-shot writes made during a conversion.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONT   = 2'd1,
        ST_SINGLE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cseq_cfg_reg.sv
// Configuration holder: resolution code, shutdown bit, one-shot trigger.
module cseq_cfg_reg #(
    parameter int unsigned RES_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RES_W+1:0] wr_data,
    output logic [RES_W-1:0] res_q,
    output logic             sd_q,
    output logic             os_pulse,
    output logic [RES_W+1:0] rd_data
);

    localparam int unsigned SD_BIT = RES_W;
    localparam int unsigned OS_BIT = RES_W + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '0;
            sd_q     <= 1'b0;
            os_pulse <= 1'b0;
        end else begin
            // trigger lives for one clock and only when shutdown is written too
            os_pulse <= wr_en & wr_data[OS_BIT] & wr_data[SD_BIT];
            if (wr_en) begin
                res_q <= wr_data[RES_W-1:0];
                sd_q  <= wr_data[SD_BIT];
            end
        end
    end

    assign rd_data = {1'b0, sd_q, res_q};

endmodule

// File: rtl/cseq_timer.sv
// Counts timebase ticks up to UNIT_TICKS << code.
module cseq_timer #(
    parameter int unsigned UNIT_TICKS = 2,
    parameter int unsigned RES_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick_en,
    input  logic [RES_W-1:0] res,
    output logic             done,
    output logic [$clog2((UNIT_TICKS << ((1 << RES_W) - 1)) + 1)-1:0] cnt_o
);

    localparam int unsigned MAX_TICKS = UNIT_TICKS << ((1 << RES_W) - 1);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = CNT_W'((UNIT_TICKS << res) - 1);
    assign done     = tick_en && (cnt_q == last_cnt);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || done) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cseq_trunc.sv
// Zeroes result bits below the selected resolution.
module cseq_trunc #(
    parameter int unsigned RAW_W    = 12,
    parameter int unsigned MIN_BITS = 9,
    parameter int unsigned RES_W    = 2
) (
    input  logic [RAW_W-1:0] raw_i,
    input  logic [RES_W-1:0] res_i,
    output logic [RAW_W-1:0] trunc_o
);

    localparam int unsigned FIXED_LSB = RAW_W - MIN_BITS;

    for (genvar gi = 0; gi < RAW_W; gi++) begin : g_bit
        if (gi >= FIXED_LSB) begin : g_keep
            assign trunc_o[gi] = raw_i[gi];
        end else begin : g_sel
            assign trunc_o[gi] = raw_i[gi] & ((gi + int'(res_i)) >= FIXED_LSB);
        end
    end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import cseq_pkg::*;
#(
    parameter int unsigned RAW_W      = 12,
    parameter int unsigned MIN_BITS   = 9,
    parameter int unsigned RES_W      = 2,
    parameter int unsigned UNIT_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cfg_we,
    input  logic [RES_W+1:0] cfg_wdata,
    output logic [RES_W+1:0] cfg_rdata,
    input  logic [RAW_W-1:0] adc_raw,
    output logic             busy,
    output logic             sample_valid,
    output logic [RAW_W-1:0] sample
);

    localparam int unsigned CNT_W = $clog2((UNIT_TICKS << ((1 << RES_W) - 1)) + 1);

    seq_state_t       state_q, state_d;
    logic             start;
    logic             done;
    logic [RES_W-1:0] res_q;
    logic             sd_q;
    logic             os_pulse;
    logic [RES_W-1:0] conv_res_q;
    logic [RAW_W-1:0] trunc_w;
    logic [CNT_W-1:0] tmr_cnt;
    logic             valid_q;
    logic [RAW_W-1:0] sample_q;

    cseq_cfg_reg #(.RES_W(RES_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_data  (cfg_wdata),
        .res_q    (res_q),
        .sd_q     (sd_q),
        .os_pulse (os_pulse),
        .rd_data  (cfg_rdata)
    );

    cseq_timer #(.UNIT_TICKS(UNIT_TICKS), .RES_W(RES_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .tick_en (busy & tick),
        .res     (conv_res_q),
        .done    (done),
        .cnt_o   (tmr_cnt)
    );

    cseq_trunc #(.RAW_W(RAW_W), .MIN_BITS(MIN_BITS), .RES_W(RES_W)) u_trunc (
        .raw_i   (adc_raw),
        .res_i   (conv_res_q),
        .trunc_o (trunc_w)
    );

    assign busy = (state_q != ST_IDLE);

    // next state and conversion start
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!sd_q) begin
                    state_d = ST_CONT;
                    start   = 1'b1;
                end else if (os_pulse) begin
                    state_d = ST_SINGLE;
                    start   = 1'b1;
                end
            end
            ST_CONT: begin
                if (done) begin
                    if (sd_q) begin
                        state_d = ST_IDLE;
                    end else begin
                        start = 1'b1;
                    end
                end
            end
            ST_SINGLE: begin
                if (done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and captured resolution
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= 1'b0;
            sample_q   <= '0;
            conv_res_q <= '0;
        end else begin
            valid_q <= done;
            if (done) begin
                sample_q <= trunc_w;
            end
            if (start) begin
                conv_res_q <= res_q;
            end
        end
    end

    assign sample_valid = valid_q;
    assign sample       = sample_q;

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk #(
    parameter int unsigned RAW_W      = 12,
    parameter int unsigned MIN_BITS   = 9,
    parameter int unsigned RES_W      = 2,
    parameter int unsigned UNIT_TICKS = 2,
    parameter int unsigned CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             sample_valid,
    input logic [RAW_W-1:0] sample,
    input logic [RES_W-1:0] conv_res,
    input logic [CNT_W-1:0] cnt
);

    function automatic logic low_clear(input logic [RAW_W-1:0] s, input logic [RES_W-1:0] r);
        int unsigned drop;
        drop = (RAW_W - MIN_BITS) - int'(r);
        for (int i = 0; i < RAW_W; i++) begin
            if (i < drop && s[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !sample_valid));

    // R4
    valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(busy));

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> sample_valid);

    // R5
    trunc_low_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> low_clear(sample, $past(conv_res)));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cnt) < int'(UNIT_TICKS << conv_res)));

endmodule

bind conv_sequencer cseq_chk #(
    .RAW_W      (RAW_W),
    .MIN_BITS   (MIN_BITS),
    .RES_W      (RES_W),
    .UNIT_TICKS (UNIT_TICKS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .sample_valid (sample_valid),
    .sample       (sample),
    .conv_res     (conv_res_q),
    .cnt          (tmr_cnt)
);

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;

    localparam int UNIT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic [3:0]  cfg_rdata;
    logic [11:0] adc_raw = 12'hA5B;
    logic        busy;
    logic        sample_valid;
    logic [11:0] sample;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit finished = 1'b0;

    conv_sequencer #(.UNIT_TICKS(UNIT)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .adc_raw(adc_raw), .busy(busy),
        .sample_valid(sample_valid), .sample(sample)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick_cnt <= 0;
            tick     <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1;
            tick     <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] trunc_exp(input logic [11:0] raw, input int res);
        return raw & ~((12'd1 << (3 - res)) - 12'd1);
    endfunction

    task automatic write_cfg(input logic os, input logic sd, input logic [1:0] res);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {os, sd, res};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_valid(output int when);
        when = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sample_valid) begin
                when = cyc;
                break;
            end
        end
    endtask

    task automatic count_valid(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_valid) hits++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(sample_valid == 1'b0, "R1 valid in reset", sample_valid, 0);
        chk(cfg_rdata == 4'h0, "R1 cfg after reset", cfg_rdata, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b1, "R1 continuous after reset", busy, 1);
    endtask

    task automatic t_continuous(input logic [1:0] res, input int div);
        int t0, t1, t2;
        tick_div = div;
        write_cfg(1'b0, 1'b0, res);
        wait_valid(t0);
        wait_valid(t0);
        wait_valid(t1);
        chk(sample == trunc_exp(adc_raw, int'(res)), "R5 truncated sample", sample, trunc_exp(adc_raw, int'(res)));
        @(negedge clk);
        chk(sample_valid == 1'b0, "R4 strobe one clock", sample_valid, 0);
        chk(busy == 1'b1, "R3 busy held", busy, 1);
        wait_valid(t2);
        chk((t2 - t1) == (UNIT << res) * div, "R2 R3 sample period", t2 - t1, (UNIT << res) * div);
    endtask

    task automatic t_os_ignored();
        int t1, t2, t3, hits;
        tick_div = 1;
        write_cfg(1'b0, 1'b0, 2'd1);
        wait_valid(t1);
        wait_valid(t1);
        write_cfg(1'b1, 1'b0, 2'd1);
        chk(busy == 1'b1, "R9 busy after ignored os", busy, 1);
        chk(cfg_rdata == 4'h1, "R8 R9 readback", cfg_rdata, 1);
        wait_valid(t2);
        wait_valid(t3);
        chk((t3 - t2) == (UNIT << 1), "R9 period kept", t3 - t2, UNIT << 1);
        // shutdown and one-shot together while running: no extra conversion
        write_cfg(1'b1, 1'b1, 2'd1);
        wait_valid(t1);
        chk(busy == 1'b0, "R9 stop after current", busy, 0);
        count_valid(80, hits);
        chk(hits == 0, "R9 no extra conversion", hits, 0);
    endtask

    task automatic t_shutdown();
        int t1, hits;
        tick_div = 1;
        write_cfg(1'b0, 1'b0, 2'd2);
        wait_valid(t1);
        write_cfg(1'b0, 1'b1, 2'd2);
        chk(cfg_rdata == 4'h6, "R8 shutdown readback", cfg_rdata, 6);
        wait_valid(t1);
        chk(t1 >= 0, "R6 final sample", t1 >= 0, 1);
        chk(busy == 1'b0, "R6 busy falls with sample", busy, 0);
        count_valid(100, hits);
        chk(hits == 0, "R6 no samples after shutdown", hits, 0);
        chk(busy == 1'b0, "R6 stays idle", busy, 0);
    endtask

    task automatic t_oneshot(input logic [1:0] res, input logic [11:0] raw);
        int t1, hits;
        adc_raw = raw;
        write_cfg(1'b1, 1'b1, res);
        chk(cfg_rdata[3] == 1'b0, "R8 one-shot reads zero", cfg_rdata[3], 0);
        chk(cfg_rdata[1:0] == res, "R8 code readback", cfg_rdata[1:0], res);
        wait_valid(t1);
        chk(t1 >= 0, "R7 one-shot sample", t1 >= 0, 1);
        chk(busy == 1'b0, "R7 back to idle", busy, 0);
        chk(sample == trunc_exp(raw, int'(res)), "R5 one-shot sample", sample, trunc_exp(raw, int'(res)));
        count_valid(80, hits);
        chk(hits == 0, "R7 single conversion only", hits, 0);
    endtask

    initial begin
        t_reset();
        t_continuous(2'd0, 1);
        t_continuous(2'd3, 1);
        t_continuous(2'd1, 3);
        t_continuous(2'd2, 2);
        t_os_ignored();
        t_shutdown();
        t_oneshot(2'd0, 12'hFFF);
        t_oneshot(2'd3, 12'h3C7);
        t_oneshot(2'd2, 12'h555);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule